// File: doc/BRIEF.md
# AES3 Transmit Framer with Block Alignment

This block assembles two-channel digital audio frames for an AES3 / S/PDIF style serial link and drives them, biphase-mark coded, onto a differential pin pair. The whole block runs on the output master clock, with one master clock per half bit cell. Each subframe carries a 4-slot preamble, a 24-bit audio word, the validity, user and channel-status bits and a parity bit. A counter groups frames into 192-frame channel-status blocks.

The block has a single boundary pin. When it is set as an input, a qualified high pulse on it forces a new frame and a new block. When it is set as an output, it marks the first frame of every block. In output mode the framer can also lock the start of the A subframe to the rising edge of the serial-port word clock. The user bit can come from a register bit or from an external pin. Separate control bits mute the audio slots and force both line outputs low.

Top module: `aes_tx_framer`

## Requirements
- R1: A frame lasts 128 master clocks: an A subframe, which carries `left_smp`, and then a B subframe, which carries `right_smp`. Each subframe has 32 slots of two half cells, one clock per half cell. Slots 0-3 hold the preamble. Slots 4-27 hold the audio word, least significant bit in slot 4. Slot 28 holds validity, slot 29 the user bit, slot 30 the channel-status bit and slot 31 parity. Sample, validity, user and channel-status inputs are captured at the first half cell of each subframe.
- R2: In slots 4-31 the line level changes at the start of every slot. It changes again in the middle of the slot when the bit is 1.
- R3: Parity makes the number of ones in slots 4-31 of every subframe even.
- R4: Preambles, as 8 half-cell levels sent left to right after a low line: the first A subframe of a block is 11101000, every other A subframe is 11100010, and every B subframe is 11100100. When the line was high before the preamble, every level is inverted.
- R5: A block is 192 frames. When `bnd_dir`=1, `bnd_oe` is 1 and `bnd_out` is high for exactly the first frame of each block. When `bnd_dir`=0, both are 0. Reset starts at frame 0 of a block.
- R6: When `bnd_dir`=0 and the synchronised `bnd_in` stays high for 4 consecutive clocks, the framer restarts at the A subframe of block frame 0. A high pulse of 3 clocks has no effect.
- R7: When `bnd_dir`=1 and `lrck_align`=1, a rising edge of `lrck` restarts an A subframe. The frame count advances by one.
- R8: While `mute` is high, audio slots are sent as zeros. Preamble, V, U, C and parity continue normally.
- R9: The user bit is `u_pin` when `u_from_pin`=1, and `u_reg_bit` otherwise.
- R10: `txp` and `txn` are both 0 during reset, while `clk_present`=0, and while `drv_off`=1. Otherwise `txn` is the complement of `txp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output master clock, one half bit cell per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | Transmit clock is valid |
| left_smp | input | 24 | A-channel audio sample |
| right_smp | input | 24 | B-channel audio sample |
| valid_flag | input | 1 | Validity bit to send |
| cs_bit | input | 1 | Channel-status bit for the next subframe |
| u_reg_bit | input | 1 | User bit from register storage |
| u_pin | input | 1 | User bit from the external pin |
| u_from_pin | input | 1 | Select the pin as user bit source |
| lrck | input | 1 | Serial-port word clock |
| lrck_align | input | 1 | Align A subframes to rising `lrck` |
| bnd_dir | input | 1 | Boundary pin direction, 1 = output |
| bnd_in | input | 1 | Boundary pin input level |
| bnd_out | output | 1 | Boundary pin output level |
| bnd_oe | output | 1 | Boundary pin output enable |
| mute | input | 1 | Send zeros in audio slots |
| drv_off | input | 1 | Force both line outputs low |
| txp | output | 1 | Positive line output |
| txn | output | 1 | Negative line output |

## Verification
A half cell is encoded at one rising edge and shows on `txp` during the next cycle, so the bench reads the line at the falling edge after each encoding edge. The input pins pass through a two-stage synchroniser. A 4-clock boundary pulse raised just after a falling edge therefore makes the new block's first half cell appear at the 7th falling edge. An `lrck` rise appears at the 4th, and the bench starts decoding exactly there. Captured fields take effect in the next subframe that starts, so the bench changes its inputs only after slot 30 has been sampled. Driver gating is combinational and is checked one time step after the control changes.

// File: rtl/aes_tx_pkg.sv
package aes_tx_pkg;
  localparam int CELL_W   = 7;   // 128 half cells per frame
  localparam int AUDIO_W  = 24;
  localparam logic [4:0] SLOT_DATA0 = 5'd4;
  localparam logic [4:0] SLOT_ALAST = 5'd27;
  localparam logic [4:0] SLOT_V     = 5'd28;
  localparam logic [4:0] SLOT_U     = 5'd29;
  localparam logic [4:0] SLOT_C     = 5'd30;
  localparam logic [4:0] SLOT_P     = 5'd31;

  typedef enum logic [1:0] {PRE_X = 2'd0, PRE_Y = 2'd1, PRE_Z = 2'd2} pre_kind_e;

  // Half-cell levels after a low line, leftmost sent first.
  function automatic logic [7:0] pre_cells(pre_kind_e k);
    case (k)
      PRE_Z:   return 8'b1110_1000;
      PRE_Y:   return 8'b1110_0100;
      default: return 8'b1110_0010;
    endcase
  endfunction

  // Biphase-mark: toggle at every slot start, toggle mid-slot for a one.
  function automatic logic bmc_level(logic prev, logic second_half, logic bit_v);
    if (!second_half) return ~prev;
    return bit_v ? ~prev : prev;
  endfunction
endpackage

// File: rtl/aes_tx_pin_cond.sv
module aes_tx_pin_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bnd_in,
  input  logic lrck,
  input  logic bnd_dir,
  input  logic lrck_align,
  output logic bnd_fire,
  output logic lrck_rise
);
  localparam int CW = $clog2(QUAL_CYCLES + 2);
  localparam logic [CW-1:0] CNT_FIRE = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] CNT_SAT  = CW'(QUAL_CYCLES + 1);

  logic [SYNC_STAGES-1:0] bnd_s, lrck_s;
  logic [CW-1:0] hi_cnt;
  logic lrck_d;
  logic bnd_sync, lrck_sync;

  assign bnd_sync  = bnd_s[SYNC_STAGES-1];
  assign lrck_sync = lrck_s[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_s  <= '0;
      lrck_s <= '0;
      lrck_d <= 1'b0;
      hi_cnt <= '0;
    end else begin
      bnd_s[0]  <= bnd_in;
      lrck_s[0] <= lrck;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        bnd_s[i]  <= bnd_s[i-1];
        lrck_s[i] <= lrck_s[i-1];
      end
      lrck_d <= lrck_sync;
      if (!bnd_sync)             hi_cnt <= '0;
      else if (hi_cnt != CNT_SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // Fires once, on the (QUAL_CYCLES+1)-th consecutive high cycle.
  assign bnd_fire  = !bnd_dir && bnd_sync && (hi_cnt == CNT_FIRE);
  assign lrck_rise = bnd_dir && lrck_align && lrck_sync && !lrck_d;
endmodule

// File: rtl/aes_tx_seq.sv
module aes_tx_seq
  import aes_tx_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_fire,
  input  logic              lrck_rise,
  output logic [CELL_W-1:0] cell_cnt,
  output logic [FW-1:0]     frame_idx,
  output pre_kind_e         pre_kind,
  output logic              block_first
);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

  function automatic logic [FW-1:0] next_frame(logic [FW-1:0] f);
    return (f == LAST_FRAME) ? '0 : f + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_cnt  <= '0;
      frame_idx <= '0;
    end else if (bnd_fire) begin
      cell_cnt  <= '0;
      frame_idx <= '0;
    end else if (lrck_rise) begin
      cell_cnt  <= '0;
      frame_idx <= next_frame(frame_idx);
    end else begin
      cell_cnt <= cell_cnt + 1'b1;
      if (&cell_cnt) frame_idx <= next_frame(frame_idx);
    end
  end

  assign block_first = (frame_idx == '0);
  assign pre_kind = cell_cnt[CELL_W-1] ? PRE_Y : (block_first ? PRE_Z : PRE_X);
endmodule

// File: rtl/aes_tx_bmc.sv
module aes_tx_bmc
  import aes_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CELL_W-1:0]  cell_cnt,
  input  pre_kind_e          pre_kind,
  input  logic [AUDIO_W-1:0] audio_in,
  input  logic               v_in,
  input  logic               u_in,
  input  logic               c_in,
  input  logic               mute,
  output logic               line_lvl,
  output logic               enc_bit
);
  logic [AUDIO_W-1:0] sh_audio;
  logic sh_v, sh_u, sh_c, par_acc, pre_inv, line_nxt;
  logic [4:0] slot;
  logic sub_start, half, data_slot, audio_slot;
  logic [7:0] pat;

  assign slot       = cell_cnt[5:1];
  assign half       = cell_cnt[0];
  assign sub_start  = (cell_cnt[5:0] == 6'd0);
  assign data_slot  = (slot >= SLOT_DATA0);
  assign audio_slot = data_slot && (slot <= SLOT_ALAST);
  assign pat        = pre_cells(pre_kind);

  always_comb begin
    enc_bit = 1'b0;
    if (audio_slot) enc_bit = mute ? 1'b0 : sh_audio[slot - SLOT_DATA0];
    else begin
      case (slot)
        SLOT_V:  enc_bit = sh_v;
        SLOT_U:  enc_bit = sh_u;
        SLOT_C:  enc_bit = sh_c;
        SLOT_P:  enc_bit = par_acc;
        default: enc_bit = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (!data_slot)
      line_nxt = pat[3'd7 - cell_cnt[2:0]] ^ (sub_start ? line_lvl : pre_inv);
    else
      line_nxt = bmc_level(line_lvl, half, enc_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_audio <= '0;
      sh_v     <= 1'b0;
      sh_u     <= 1'b0;
      sh_c     <= 1'b0;
      par_acc  <= 1'b0;
      pre_inv  <= 1'b0;
      line_lvl <= 1'b0;
    end else begin
      line_lvl <= line_nxt;
      if (sub_start) begin
        sh_audio <= audio_in;
        sh_v     <= v_in;
        sh_u     <= u_in;
        sh_c     <= c_in;
        par_acc  <= 1'b0;
        pre_inv  <= line_lvl;
      end else if (half && data_slot && slot != SLOT_P) begin
        par_acc <= par_acc ^ enc_bit;
      end
    end
  end
endmodule

// File: rtl/aes_tx_framer.sv
module aes_tx_framer
  import aes_tx_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_present,
  input  logic [23:0] left_smp,
  input  logic [23:0] right_smp,
  input  logic        valid_flag,
  input  logic        cs_bit,
  input  logic        u_reg_bit,
  input  logic        u_pin,
  input  logic        u_from_pin,
  input  logic        lrck,
  input  logic        lrck_align,
  input  logic        bnd_dir,
  input  logic        bnd_in,
  output logic        bnd_out,
  output logic        bnd_oe,
  input  logic        mute,
  input  logic        drv_off,
  output logic        txp,
  output logic        txn
);
  localparam int FW = $clog2(FRAMES);

  logic bnd_fire, lrck_rise, block_first, line_lvl, enc_bit, drv_en;
  logic [CELL_W-1:0] cell_cnt;
  logic [FW-1:0] frame_idx;
  pre_kind_e pre_kind;
  logic [AUDIO_W-1:0] audio_sel;

  aes_tx_pin_cond #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) cond_i (
    .clk(clk), .rst_n(rst_n), .bnd_in(bnd_in), .lrck(lrck), .bnd_dir(bnd_dir),
    .lrck_align(lrck_align), .bnd_fire(bnd_fire), .lrck_rise(lrck_rise)
  );

  aes_tx_seq #(.FRAMES(FRAMES)) seq_i (
    .clk(clk), .rst_n(rst_n), .bnd_fire(bnd_fire), .lrck_rise(lrck_rise),
    .cell_cnt(cell_cnt), .frame_idx(frame_idx), .pre_kind(pre_kind),
    .block_first(block_first)
  );

  assign audio_sel = cell_cnt[CELL_W-1] ? right_smp : left_smp;

  aes_tx_bmc bmc_i (
    .clk(clk), .rst_n(rst_n), .cell_cnt(cell_cnt), .pre_kind(pre_kind),
    .audio_in(audio_sel), .v_in(valid_flag),
    .u_in(u_from_pin ? u_pin : u_reg_bit), .c_in(cs_bit), .mute(mute),
    .line_lvl(line_lvl), .enc_bit(enc_bit)
  );

  assign drv_en  = rst_n && clk_present && !drv_off;
  assign txp     = drv_en && line_lvl;
  assign txn     = drv_en && !line_lvl;
  assign bnd_oe  = bnd_dir;
  assign bnd_out = bnd_dir && block_first;
endmodule

// File: rtl/aes_tx_framer_chk.sv
module aes_tx_framer_chk #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    cell_cnt,
  input logic [FW-1:0] frame_idx,
  input logic          line_lvl,
  input logic          bnd_fire,
  input logic          lrck_rise,
  input logic          mute,
  input logic          drv_off,
  input logic          clk_present,
  input logic          bnd_dir,
  input logic          bnd_out,
  input logic          txp,
  input logic          txn
);
  logic [4:0] slot;
  assign slot = cell_cnt[5:1];

  assert_frame_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx < FW'(FRAMES));

  assert_block_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bnd_out) && $stable(bnd_dir)) |-> (cell_cnt == 7'd0));

  assert_slot_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot >= 5'd4 && !cell_cnt[0]) |=> (line_lvl != $past(line_lvl)));

  assert_bnd_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_fire |=> (cell_cnt == 7'd0 && frame_idx == '0));

  assert_lrck_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_rise |=> (cell_cnt == 7'd0));

  assert_mute_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && cell_cnt[0] && slot >= 5'd4 && slot <= 5'd27) |=> (line_lvl == $past(line_lvl)));

  assert_drv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_off || !clk_present) |-> (!txp && !txn));

  assert_rst_ground_R10: assert property (@(posedge clk)
    !rst_n |-> (!txp && !txn));
endmodule

bind aes_tx_framer aes_tx_framer_chk #(.FRAMES(FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cell_cnt(cell_cnt), .frame_idx(frame_idx),
  .line_lvl(line_lvl), .bnd_fire(bnd_fire), .lrck_rise(lrck_rise), .mute(mute),
  .drv_off(drv_off), .clk_present(clk_present), .bnd_dir(bnd_dir),
  .bnd_out(bnd_out), .txp(txp), .txn(txn)
);

// File: tb/aes_tx_framer_tb_top.sv
module aes_tx_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n, clk_present, valid_flag, cs_bit, u_reg_bit, u_pin, u_from_pin;
  logic lrck, lrck_align, bnd_dir, bnd_in, bnd_out, bnd_oe, mute, drv_off, txp, txn;
  logic [23:0] left_smp, right_smp;

  int n_chk = 0, n_bad = 0, fcount = 0;
  logic last_lvl = 1'b0;
  bit done = 1'b0, rand_en = 1'b1;

  always #4 clk = ~clk;

  aes_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .clk_present(clk_present), .left_smp(left_smp),
    .right_smp(right_smp), .valid_flag(valid_flag), .cs_bit(cs_bit),
    .u_reg_bit(u_reg_bit), .u_pin(u_pin), .u_from_pin(u_from_pin), .lrck(lrck),
    .lrck_align(lrck_align), .bnd_dir(bnd_dir), .bnd_in(bnd_in), .bnd_out(bnd_out),
    .bnd_oe(bnd_oe), .mute(mute), .drv_off(drv_off), .txp(txp), .txn(txn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Preamble levels after a low line; 0=A first of block, 1=other A, 2=B
  function automatic logic [7:0] exp_pre(input int kind);
    if (kind == 0) return 8'hE8;
    if (kind == 1) return 8'hE2;
    return 8'hE4;
  endfunction

  function automatic logic [26:0] exp_fields(input logic [23:0] a, input logic v,
                                             input logic u, input logic c, input logic m);
    return {c, u, v, (m ? 24'd0 : a)};
  endfunction

  task automatic tick();
    @(negedge clk);
    last_lvl = txp;
  endtask

  task automatic new_inputs();
    int p;
    p = int'($urandom % 8);
    left_smp  = (p == 0) ? 24'hFFFFFF : (p == 1) ? 24'h0 : 24'($urandom);
    p = int'($urandom % 8);
    right_smp = (p == 0) ? 24'hFFFFFF : (p == 1) ? 24'h000001 : 24'($urandom);
    valid_flag = 1'($urandom);
    cs_bit     = 1'($urandom);
    u_reg_bit  = 1'($urandom);
    u_pin      = 1'($urandom);
    u_from_pin = 1'($urandom);
    mute       = (($urandom % 6) == 0);
  endtask

  task automatic decode_sub(input bit is_b);
    logic [63:0] s;
    logic p0, prev, bmc_ok, e_u, e_m;
    logic [7:0] pre;
    logic [27:0] w;
    logic [26:0] e;
    int kind;
    p0   = last_lvl;
    e_u  = u_from_pin ? u_pin : u_reg_bit;
    e_m  = mute;
    e    = exp_fields(is_b ? right_smp : left_smp, valid_flag, e_u, cs_bit, mute);
    kind = is_b ? 2 : ((fcount == 0) ? 0 : 1);
    for (int i = 0; i < 64; i++) begin
      tick();
      s[i] = txp;
      if (i == 0) begin
        chk(txn == ~txp, "R10", "txn complements txp", {31'd0, txn}, {31'd0, ~txp});
        if (bnd_dir && !is_b)
          chk(bnd_out == (fcount == 0), "R5", "block marker",
              {31'd0, bnd_out}, {31'd0, fcount == 0});
      end
      if (i == 60 && rand_en) new_inputs();
    end
    for (int i = 0; i < 8; i++) pre[7-i] = s[i] ^ p0;
    chk(pre == exp_pre(kind), "R4", "preamble", {24'd0, pre}, {24'd0, exp_pre(kind)});
    prev = s[7];
    bmc_ok = 1'b1;
    for (int j = 0; j < 28; j++) begin
      if (s[8+2*j] == prev) bmc_ok = 1'b0;
      w[j] = s[8+2*j] ^ s[9+2*j];
      prev = s[9+2*j];
    end
    chk(bmc_ok, "R2", "slot start transition", {31'd0, bmc_ok}, 32'd1);
    chk(w[26:0] == e, "R1", "subframe fields", {5'd0, w[26:0]}, {5'd0, e});
    chk(w[25] == e_u, "R9", "user bit source", {31'd0, w[25]}, {31'd0, e_u});
    if (e_m) chk(w[23:0] == 24'd0, "R8", "muted audio", {8'd0, w[23:0]}, 32'd0);
    chk(^w == 1'b0, "R3", "even parity", {4'd0, w}, {4'd0, w[26:0], ^w[26:0]});
  endtask

  task automatic decode_frame();
    decode_sub(1'b0);
    decode_sub(1'b1);
    fcount = (fcount + 1) % 192;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_A3E5));
    rst_n = 1'b0; clk_present = 1'b1; drv_off = 1'b0;
    lrck = 1'b0; lrck_align = 1'b0; bnd_dir = 1'b1; bnd_in = 1'b0;
    new_inputs();
    mute = 1'b0;
    repeat (3) @(negedge clk);
    chk(!txp && !txn, "R10", "lines low in reset", {30'd0, txp, txn}, 32'd0);
    chk(bnd_out && bnd_oe, "R5", "reset at block start", {30'd0, bnd_out, bnd_oe}, 32'd3);
    last_lvl = 1'b0;
    rst_n = 1'b1;
    // Two full blocks plus a few frames of random traffic (R1-R5, R8, R9)
    for (int f = 0; f < 390; f++) decode_frame();

    // R6: boundary pin as input, 3-clock pulse ignored
    bnd_dir = 1'b0;
    #1 chk(!bnd_out && !bnd_oe, "R5", "marker off as input", {30'd0, bnd_out, bnd_oe}, 32'd0);
    fork
      decode_sub(1'b0);
      begin
        bnd_in = 1'b1;
        repeat (3) @(negedge clk);
        bnd_in = 1'b0;
      end
    join
    decode_sub(1'b1);
    fcount = (fcount + 1) % 192;
    decode_frame();

    // R6: 4-clock pulse restarts a block
    bnd_in = 1'b1;
    repeat (4) tick();
    bnd_in = 1'b0;
    repeat (2) tick();
    fcount = 0;
    decode_frame();
    decode_frame();

    // R7: align A subframe to rising lrck, frame count advances
    bnd_dir = 1'b1;
    lrck_align = 1'b1;
    lrck = 1'b1;
    repeat (3) tick();
    fcount = (fcount + 1) % 192;
    decode_frame();
    decode_frame();
    lrck = 1'b0;
    decode_frame();

    // R10: driver gating
    @(negedge clk);
    chk(txp ^ txn, "R10", "one line driven", {30'd0, txp, txn}, 32'd1);
    drv_off = 1'b1;
    #1 chk(!txp && !txn, "R10", "drv_off grounds lines", {30'd0, txp, txn}, 32'd0);
    drv_off = 1'b0;
    clk_present = 1'b0;
    #1 chk(!txp && !txn, "R10", "no clock grounds lines", {30'd0, txp, txn}, 32'd0);
    clk_present = 1'b1;
    #1 chk(txp ^ txn, "R10", "lines restored", {30'd0, txp, txn}, 32'd1);
    report();
  end
endmodule